// File: doc/BRIEF.md
# Zero-Parity and One-Modulo-3 History Detector

This block reads a serial stream one bit per clock, and only on cycles where the qualifier is high. Over the whole history since the last reset it keeps two remainders: the number of accepted 0 bits taken modulo 2, and the number of accepted 1 bits taken modulo 3. Its flag is high exactly when both remainders equal 1. It looks for no fixed bit pattern. It is a six-state product machine, so there is no overlap handling.

The machine is built twice inside the top module, and both copies use the same three-bit state code. The first copy is written behaviourally as an enumerated state register. The second copy is structural: it uses three JK flip-flops driven by minimised excitation equations. Both flags come out at the ports so that the two forms can be compared cycle by cycle. The remainders of the behavioural copy are also brought out as a debug port.

In the state code, bit 2 holds the zero remainder and bits 1:0 hold the one remainder. The code 2'b11 in bits 1:0 is unused. If the machine ever lands on an unused code, it returns to the reset state on the next clock.

Top module: `seq_resid_det`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next state is zero remainder 0 and one remainder 0. Right after that edge `zres`=0, `ores`=0, `detect`=0 and `detect_jk`=0.
- R2: An edge with `bit_vld`=1 and `bit_in`=0 inverts `zres` and leaves `ores` unchanged.
- R3: An edge with `bit_vld`=1 and `bit_in`=1 steps `ores` through 0→1→2→0 and leaves `zres` unchanged.
- R4: An edge with `bit_vld`=0 (and `rst`=0) leaves `zres`, `ores`, `detect` and `detect_jk` unchanged, whatever `bit_in` is.
- R5: `detect` is a registered (Moore) output. It is 1 exactly when `zres`=1 and `ores`=1, so it changes only on the edge that accepts a bit.
- R6: `detect_jk` from the JK flip-flop implementation equals `detect` on every cycle.
- R7: `ores` never shows the unused value 3.
- R8: The condition covers all accepted bits since reset, with no window. For example, accepting 0,1 sets `detect`. Accepting six more 1s and two more 0s after that brings `detect` back to 1, and it is low at the intermediate points where either remainder is not 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one bit is accepted per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Serial data bit |
| bit_vld | input | 1 | Qualifier; bit_in is accepted only when high |
| detect | output | 1 | Flag from the behavioural machine |
| detect_jk | output | 1 | Flag from the JK flip-flop machine |
| zres | output | 1 | Debug: count of accepted zeros modulo 2 |
| ores | output | 2 | Debug: count of accepted ones modulo 3 |

## Verification
The hardest case to reach from the ports is the one where the one remainder wraps from 2 to 0. It should happen while the zero remainder sits at each of its two values, and it should be interleaved with held cycles. A rotating 5-bit pattern alone repeats too quickly to cover every transition with holds in between. The stimulus therefore preloads several 5-bit patterns, including all-ones and all-zeros. It rotates each pattern under a random qualifier, and adds a directed walk that comes back to the detecting state after many ones and zeros, plus a reset in the middle of the stream.

// File: rtl/det_pkg.sv
package det_pkg;
  localparam int ZERO_MOD = 2;
  localparam int ONE_MOD  = 3;
  localparam int ZW       = $clog2(ZERO_MOD);
  localparam int OW       = $clog2(ONE_MOD);
  localparam int SW       = ZW + OW;

  typedef enum logic [SW-1:0] {
    ST_Z0_O0 = 3'b000,
    ST_Z0_O1 = 3'b001,
    ST_Z0_O2 = 3'b010,
    ST_Z1_O0 = 3'b100,
    ST_Z1_O1 = 3'b101,
    ST_Z1_O2 = 3'b110
  } st_t;

  function automatic logic [ZW-1:0] zero_step(input logic [ZW-1:0] z, input logic take0);
    return take0 ? ~z : z;
  endfunction

  function automatic logic [OW-1:0] one_step(input logic [OW-1:0] o, input logic take1);
    logic [OW-1:0] r;
    r = o;
    if (take1) r = (o == OW'(ONE_MOD - 1)) ? '0 : o + 1'b1;
    return r;
  endfunction

  function automatic logic code_bad(input logic [SW-1:0] s);
    return s[OW-1:0] >= OW'(ONE_MOD);
  endfunction

  function automatic logic is_hit(input logic [SW-1:0] s);
    return (s[SW-1 -: ZW] == ZW'(1)) && (s[OW-1:0] == OW'(1));
  endfunction
endpackage

// File: rtl/jk_ff.sv
module jk_ff (
  input  logic clk,
  input  logic rst,
  input  logic j,
  input  logic k,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else begin
      case ({j, k})
        2'b00: q <= q;
        2'b01: q <= 1'b0;
        2'b10: q <= 1'b1;
        default: q <= ~q;
      endcase
    end
  end
endmodule

// File: rtl/resid_behav.sv
module resid_behav
  import det_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          take0,
  input  logic          take1,
  output logic [SW-1:0] state_q,
  output logic          hit
);
  st_t cur, nxt;

  always_comb begin
    nxt = cur;
    if (code_bad(cur)) nxt = ST_Z0_O0;
    else nxt = st_t'({zero_step(cur[SW-1 -: ZW], take0), one_step(cur[OW-1:0], take1)});
  end

  always_ff @(posedge clk) begin
    if (rst) cur <= ST_Z0_O0;
    else     cur <= nxt;
  end

  assign state_q = cur;
  assign hit     = is_hit(cur);
endmodule

// File: rtl/resid_jk.sv
module resid_jk
  import det_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          take0,
  input  logic          take1,
  output logic [SW-1:0] state_q,
  output logic          hit
);
  logic [SW-1:0] q, jv, kv;
  logic bad;

  assign bad = q[1] & q[0];

  // zero remainder: toggles on accepted 0, cleared from unused codes
  assign jv[2] = take0 & ~bad;
  assign kv[2] = take0 | bad;
  // one remainder, low bit: 00->01 sets, 01->10 clears, 11 clears
  assign jv[0] = take1 & ~q[1];
  assign kv[0] = take1 | q[1];
  // one remainder, high bit: 01->10 sets, 10->00 clears, 11 clears
  assign jv[1] = take1 & q[0];
  assign kv[1] = take1 | q[0];

  for (genvar i = 0; i < SW; i++) begin : g_bit
    jk_ff u_ff (.clk(clk), .rst(rst), .j(jv[i]), .k(kv[i]), .q(q[i]));
  end

  assign state_q = q;
  assign hit     = q[2] & ~q[1] & q[0];
endmodule

// File: rtl/seq_resid_det.sv
module seq_resid_det
  import det_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_in,
  input  logic          bit_vld,
  output logic          detect,
  output logic          detect_jk,
  output logic [ZW-1:0] zres,
  output logic [OW-1:0] ores
);
  logic          zero_evt, one_evt;
  logic [SW-1:0] st_b, st_s;

  assign zero_evt = bit_vld & ~bit_in;
  assign one_evt  = bit_vld & bit_in;

  resid_behav u_behav (.clk(clk), .rst(rst), .take0(zero_evt), .take1(one_evt),
                       .state_q(st_b), .hit(detect));
  resid_jk    u_jk    (.clk(clk), .rst(rst), .take0(zero_evt), .take1(one_evt),
                       .state_q(st_s), .hit(detect_jk));

  assign zres = st_b[SW-1 -: ZW];
  assign ores = st_b[OW-1:0];
endmodule

// File: rtl/seq_resid_det_chk.sv
module seq_resid_det_chk
  import det_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic          zero_evt,
  input logic          one_evt,
  input logic          detect,
  input logic          detect_jk,
  input logic [ZW-1:0] zres,
  input logic [OW-1:0] ores
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (zres == '0 && ores == '0 && !detect && !detect_jk));

  a_r2_zero_toggle: assert property (@(posedge clk) disable iff (rst)
    zero_evt |=> (zres != $past(zres) && ores == $past(ores)));

  a_r3_one_advance: assert property (@(posedge clk) disable iff (rst)
    one_evt |=> (zres == $past(zres) &&
                 ores == (($past(ores) == OW'(2)) ? OW'(0) : $past(ores) + 1'b1)));

  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (!zero_evt && !one_evt) |=> ($stable(zres) && $stable(ores) && $stable(detect)));

  a_r5_moore_flag: assert property (@(posedge clk) disable iff (rst)
    detect |-> (zres == ZW'(1) && ores == OW'(1)));

  a_r6_forms_agree: assert property (@(posedge clk) disable iff (rst)
    detect == detect_jk);

  a_r7_no_code3: assert property (@(posedge clk) disable iff (rst)
    ores != OW'(3));
endmodule

bind seq_resid_det seq_resid_det_chk u_chk (
  .clk(clk), .rst(rst), .zero_evt(zero_evt), .one_evt(one_evt),
  .detect(detect), .detect_jk(detect_jk), .zres(zres), .ores(ores)
);

// File: tb/seq_resid_det_tb_top.sv
`timescale 1ns/1ps
module seq_resid_det_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_in = 1'b0;
  logic bit_vld = 1'b0;
  logic detect, detect_jk;
  logic [0:0] zres;
  logic [1:0] ores;

  int n_chk = 0;
  int n_err = 0;
  int zeros = 0;
  int ones = 0;
  logic [4:0] sr;

  always #2.5 clk = ~clk;

  seq_resid_det dut_i (.clk(clk), .rst(rst), .bit_in(bit_in), .bit_vld(bit_vld),
                       .detect(detect), .detect_jk(detect_jk), .zres(zres), .ores(ores));

  function automatic int exp_z(int nz); return nz % 2; endfunction
  function automatic int exp_o(int no); return no % 3; endfunction
  function automatic int exp_hit(int nz, int no);
    return (exp_z(nz) == 1 && exp_o(no) == 1) ? 1 : 0;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d (zeros=%0d ones=%0d)", tag, act, exp, zeros, ones);
    end
  endtask

  task automatic check_all(logic was_hold, int pz, int po, int pd);
    chk("R2 zres", int'(zres), exp_z(zeros));
    chk("R3 ores", int'(ores), exp_o(ones));
    chk("R5 detect", int'(detect), exp_hit(zeros, ones));
    chk("R6 detect_jk", int'(detect_jk), exp_hit(zeros, ones));
    chk("R7 ores not 3", int'(ores == 2'd3), 0);
    if (was_hold) begin
      chk("R4 hold zres", int'(zres), pz);
      chk("R4 hold ores", int'(ores), po);
      chk("R4 hold detect", int'(detect), pd);
    end
  endtask

  task automatic step(logic b, logic v);
    int pz, po, pd;
    pz = int'(zres); po = int'(ores); pd = int'(detect);
    bit_in = b; bit_vld = v;
    @(posedge clk); #1;
    if (v) begin
      if (b) ones++; else zeros++;
    end
    check_all(!v, pz, po, pd);
  endtask

  task automatic do_reset();
    rst = 1'b1; bit_vld = 1'b0;
    @(posedge clk); #1;
    @(posedge clk); #1;
    zeros = 0; ones = 0;
    chk("R1 zres", int'(zres), 0);
    chk("R1 ores", int'(ores), 0);
    chk("R1 detect", int'(detect), 0);
    chk("R1 detect_jk", int'(detect_jk), 0);
    rst = 1'b0;
  endtask

  task automatic run_ring(logic [4:0] pat, int n, int vld_pct);
    sr = pat;
    for (int i = 0; i < n; i++) begin
      logic v;
      v = (($urandom % 100) < vld_pct);
      step(sr[0], v);
      if (v) sr = {sr[0], sr[4:1]};
    end
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    do_reset();

    // R8 directed: 0,1 -> hit; then six 1s and two 0s with holds between
    step(1'b0, 1'b1);
    chk("R8 after 0", int'(detect), 0);
    step(1'b1, 1'b1);
    chk("R8 after 0,1", int'(detect), 1);
    step(1'b1, 1'b0);
    chk("R8 hold keeps hit", int'(detect), 1);
    for (int i = 0; i < 6; i++) begin
      step(1'b1, 1'b1);
      step(1'b0, 1'b0);
    end
    chk("R8 after 6 more ones", int'(detect), 1);
    step(1'b0, 1'b1);
    chk("R8 zero parity off", int'(detect), 0);
    step(1'b0, 1'b1);
    chk("R8 back to hit", int'(detect), 1);
    step(1'b1, 1'b1);
    step(1'b1, 1'b1);
    chk("R3 wrap ones=2 mod3", int'(ores), 0);
    step(1'b1, 1'b1);
    chk("R8 hit after wrap", int'(detect), 1);

    // reset in the middle of the stream
    do_reset();

    run_ring(5'b00011, 60, 70);
    run_ring(5'b10110, 60, 50);
    run_ring(5'b11111, 40, 80);
    run_ring(5'b00000, 30, 60);
    do_reset();
    for (int p = 0; p < 40; p++) begin
      run_ring(5'($urandom), 25, 20 + int'($urandom % 80));
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule